// File: doc/BRIEF.md
# PHY Test Register Access Port

This block is the slave side of a narrow test port that reaches the configuration bytes of a display PHY. A host drives five lines: a clear level, a strobe, a phase-select level, an 8-bit input byte and an 8-bit readback byte. Every rising strobe edge does one of two things. With the phase select high, the input byte becomes the current register address. With it low, the input byte is stored into the register at the current address. A read needs only an address phase: the addressed register's value then stays on the readback byte until the next address phase.

All test lines are asynchronous to the block. They pass through a two-stage synchronizer into the system clock domain, and the strobe is edge-detected there. The bank holds a parameterizable number of 8-bit registers, up to 256. Each one has a computed power-on value. Raising the clear line restores every register and the address to those values.

Top module: `phy_test_regbank`

## Requirements
- R1: After system reset the current address is 0, and `tst_dout` shows the default of register 0 (0x05).
- R2: Register i resets to (37*i + 5) mod 256, both after system reset and after a clear.
- R3: A rising `tst_clk` edge with `tst_en` high loads `tst_din` as the current address. `tst_dout` shows that register no later than four system clocks after the edge at the pin.
- R4: A rising `tst_clk` edge with `tst_en` low stores `tst_din` into the register at the current address. `tst_dout` shows the new value within four system clocks.
- R5: Only rising edges of `tst_clk` act. A falling edge, or a high level held while `tst_en` and `tst_din` change, neither writes nor changes the address.
- R6: While `tst_clr` is high, strobe edges are ignored. Once it is released, the address is 0 and every register holds its R2 default.
- R7: Addresses at or above NUM_REGS (default 192) read as 0x00. Writes to them are dropped.
- R8: The current address persists across data phases, so several writes in a row go to the same register and the last one wins.
- R9: A data phase leaves every register other than the addressed one unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tst_clr | input | 1 | Asynchronous clear level; high restores defaults |
| tst_clk | input | 1 | Asynchronous strobe; rising edges act |
| tst_en | input | 1 | Phase select: high = address phase, low = data phase |
| tst_din | input | 8 | Address or data byte |
| tst_dout | output | 8 | Content of the currently addressed register |

## Verification
The hardest case to reach from the ports is a strobe that stays high while the phase select and the data byte change under it. Catching a design that acts on levels or on falling edges needs exactly that. Directed sequences therefore raise the strobe in an address phase, switch to a data-phase pattern while it is still high, and then let it fall. A later address phase reads the register back to show it was not touched. Random mixes of address and data phases run across the full 8-bit address range, including the unimplemented addresses. After a mid-run clear, a full sweep of all 256 addresses compares every register against its computed default.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // raw test-port lines, packed so one synchronizer carries all of them
    typedef struct packed {
        logic  clr;
        logic  strobe;
        logic  phase_sel;
        byte_t din;
    } tst_lines_t;

    localparam int LINES_W = $bits(tst_lines_t);

    // decoded per-cycle action in the system domain
    typedef struct packed {
        logic  clear;
        logic  load_addr;
        logic  store_data;
        byte_t value;
    } tst_action_t;

    function automatic byte_t reg_default(input int idx);
        int v;
        v = (idx * 37 + 5) % 256;
        return byte_t'(v);
    endfunction

endpackage

// File: rtl/tst_input_sync.sv
module tst_input_sync #(
    parameter int WIDTH  = 11,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tst_phase_decode.sv
module tst_phase_decode
    import phy_tst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tst_lines_t  lines_s,
    output tst_action_t action
);
    logic strobe_prev_q;
    logic strobe_rise;

    always_ff @(posedge clk) begin
        if (rst) strobe_prev_q <= 1'b0;
        else     strobe_prev_q <= lines_s.strobe;
    end

    assign strobe_rise = lines_s.strobe & ~strobe_prev_q;

    always_comb begin
        action.clear      = lines_s.clr;
        action.load_addr  = strobe_rise &  lines_s.phase_sel & ~lines_s.clr;
        action.store_data = strobe_rise & ~lines_s.phase_sel & ~lines_s.clr;
        action.value      = lines_s.din;
    end

    // a rising edge is seen for exactly one system cycle
    assert_single_rise_R5: assert property (@(posedge clk) disable iff (rst)
        strobe_rise |=> !strobe_rise);

    assert_one_action_R5: assert property (@(posedge clk) disable iff (rst)
        !(action.load_addr && action.store_data));
endmodule

// File: rtl/tst_reg_array.sv
module tst_reg_array
    import phy_tst_pkg::*;
#(
    parameter int NUM_REGS = 192
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  byte_t wr_data,
    input  addr_t rd_addr,
    output byte_t rd_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] flat;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            localparam addr_t MY_ADDR = addr_t'(i);
            localparam byte_t MY_INIT = reg_default(i);
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst || clear)                      q <= MY_INIT;
                else if (wr_en && wr_addr == MY_ADDR)  q <= wr_data;
            end
            assign flat[i] = q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == addr_t'(i)) rd_data = flat[i];
        end
    end
endmodule

// File: rtl/phy_test_regbank.sv
module phy_test_regbank
    import phy_tst_pkg::*;
#(
    parameter int NUM_REGS    = 192,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tst_clr,
    input  logic       tst_clk,
    input  logic       tst_en,
    input  logic [7:0] tst_din,
    output logic [7:0] tst_dout
);
    tst_lines_t  lines_raw;
    tst_lines_t  lines_s;
    tst_action_t action;
    addr_t       addr_q;
    byte_t       rd_data;
    byte_t       dout_q;

    assign lines_raw = '{clr: tst_clr, strobe: tst_clk, phase_sel: tst_en, din: tst_din};

    tst_input_sync #(.WIDTH(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(lines_raw),
        .sync_out(lines_s)
    );

    tst_phase_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .lines_s(lines_s),
        .action (action)
    );

    always_ff @(posedge clk) begin
        if (rst || action.clear)   addr_q <= '0;
        else if (action.load_addr) addr_q <= action.value;
    end

    tst_reg_array #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .clear  (action.clear),
        .wr_en  (action.store_data),
        .wr_addr(addr_q),
        .wr_data(action.value),
        .rd_addr(addr_q),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) dout_q <= reg_default(0);
        else     dout_q <= rd_data;
    end

    assign tst_dout = dout_q;

    // R3: the address only moves on an address phase or a clear
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!action.load_addr && !action.clear) |=> $stable(addr_q));

    // R6: clear drives the address back to zero
    assert_clear_addr_R6: assert property (@(posedge clk) disable iff (rst)
        action.clear |=> (addr_q == '0));

    // R7: unimplemented addresses read as zero
    assert_oor_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(addr_q) >= NUM_REGS) |=> (tst_dout == '0));

    // R4: stored byte reaches the readback two cycles after the data phase
    assert_write_visible_R4: assert property (@(posedge clk) disable iff (rst || action.clear)
        (action.store_data && int'(addr_q) < NUM_REGS) |=> ##1 (tst_dout == $past(action.value, 2)));
endmodule

// File: tb/phy_test_regbank_tb.sv
module phy_test_regbank_tb;
    localparam int NREG = 192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tst_clr = 1'b0;
    logic       tst_clk = 1'b0;
    logic       tst_en = 1'b0;
    logic [7:0] tst_din = 8'h00;
    logic [7:0] tst_dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [256];
    logic [7:0] cur_addr;

    always #10 clk = ~clk;

    phy_test_regbank #(.NUM_REGS(NREG)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .tst_clr (tst_clr),
        .tst_clk (tst_clk),
        .tst_en  (tst_en),
        .tst_din (tst_din),
        .tst_dout(tst_dout)
    );

    function automatic logic [7:0] dflt(input int i);
        return 8'((i * 37 + 5) % 256);
    endfunction

    function automatic logic [7:0] expect_at(input logic [7:0] a);
        return (int'(a) < NREG) ? model[a] : 8'h00;
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 256; i++) model[i] = (i < NREG) ? dflt(i) : 8'h00;
        cur_addr = 8'h00;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic en, input logic [7:0] b);
        tst_en  = en;
        tst_din = b;
        wait_clk(3);
        tst_clk = 1'b1;
        wait_clk(5);
        tst_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic set_addr(input logic [7:0] a);
        strobe(1'b1, a);
        cur_addr = a;
    endtask

    task automatic put_data(input logic [7:0] d);
        strobe(1'b0, d);
        if (int'(cur_addr) < NREG) model[cur_addr] = d;
    endtask

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (tst_dout !== exp) begin
            errors++;
            $display("FAIL %s: addr %02h dout %02h expected %02h", req, cur_addr, tst_dout, exp);
        end
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        set_addr(a);
        check(req, expect_at(a));
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_defaults();
        wait_clk(4);
        rst = 1'b0;
        wait_clk(3);

        // R1: reset state
        check("R1", 8'h05);

        // R2: defaults at a few places
        read_check("R2", 8'd1);
        read_check("R2", 8'd100);
        read_check("R2", 8'(NREG - 1));

        // R3 / R4: address then write, readback follows
        set_addr(8'd10);
        check("R3", dflt(10));
        put_data(8'hA7);
        check("R4", 8'hA7);

        // R8: consecutive writes at one address, address persists
        put_data(8'h11);
        put_data(8'h22);
        check("R8", 8'h22);

        // R9: neighbours untouched
        read_check("R9", 8'd9);
        read_check("R9", 8'd11);
        read_check("R8", 8'd10);

        // R5: strobe held high while phase and data change, then falls
        tst_en = 1'b1; tst_din = 8'd20;
        wait_clk(3);
        tst_clk = 1'b1;
        wait_clk(5);
        cur_addr = 8'd20;
        tst_en = 1'b0; tst_din = 8'h5A;
        wait_clk(6);
        tst_din = 8'd30; tst_en = 1'b1;
        wait_clk(6);
        tst_clk = 1'b0;
        wait_clk(6);
        check("R5", dflt(20));
        read_check("R5", 8'd30);
        read_check("R5", 8'd20);

        // R7: out-of-range write dropped, reads zero
        set_addr(8'd200);
        check("R7", 8'h00);
        put_data(8'hFF);
        check("R7", 8'h00);
        read_check("R7", 8'd255);
        read_check("R7", 8'd200);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int pick;
            pick = int'($urandom_range(0, 2));
            if (pick == 0) begin
                set_addr(8'($urandom_range(0, 255)));
                check("R3", expect_at(cur_addr));
            end else begin
                put_data(8'($urandom_range(0, 255)));
                check("R4", expect_at(cur_addr));
            end
        end

        // R6: clear with a data strobe during it
        set_addr(8'd5);
        tst_clr = 1'b1;
        wait_clk(4);
        strobe(1'b0, 8'h3C);
        strobe(1'b1, 8'd7);
        tst_clr = 1'b0;
        wait_clk(6);
        model_defaults();
        check("R6", dflt(0));
        for (int a = 0; a < 256; a++) read_check("R6", 8'(a));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, dout %02h expected completion", tst_dout);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule